// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Unit

This block performs one integer butterfly step of a fixed-point DCT, DFT or FFT kernel. On each accepted issue it takes two signed operands `a` and `b`, a signed coefficient `c` and a shift amount `n`. It forms the sum `a+b` and the difference `a-b`, multiplies each by `c`, and rounds each product to nearest by a power of two. The two results come out together in the same cycle. A kernel that would otherwise need eight scalar operations per butterfly issues one. Running the unit twice with swapped operands and a second coefficient gives the two-coefficient form.

Each result is the low XLEN bits of the signed product, plus a single bit at position `n-1`, then shifted right arithmetically by `n`. The shift is built as a rotate right followed by a mask, and the vacated high bits are filled with the sign of the rounded product. Video codecs typically use `n = 14`. The first result targets destination register `rt` and the second targets the implicit register `rt+1`. The unit outputs both register indices. If the reserved record bit is set on an issue, the unit flags the issue as illegal and writes no results.

Top module: `tbf_twin_round`

## Requirements
- R1: One cycle after a legal issue, `out_rt_val` equals `((a+b)*c + 2^(n-1)) >>> n`, computed modulo 2^XLEN, where `n` is `in_shift`.
- R2: In the same cycle, `out_rs_val` equals `((a-b)*c + 2^(n-1)) >>> n`, computed from the same operands.
- R3: The sum, the difference and each product keep only their low XLEN bits. Overflow wraps and is not saturated.
- R4: When `n = 0`, no rounding bit is added and no shift is applied, so each result equals the truncated product.
- R5: Rounding breaks ties toward positive infinity. The shifted-in high bits copy bit XLEN-1 of the rounded product, so negative results stay negative. For example, -3 with `n=1` gives -1, and 3 with `n=1` gives 2.
- R6: One cycle after a legal issue, `out_rt_idx` equals `in_rt` and `out_rs_idx` equals `in_rt+1` modulo 32, so an `rt` of 31 pairs with index 0.
- R7: An issue with `in_rc = 1` sets `out_illegal = 1` and `out_wr = 0` one cycle later. The result values and indices keep their previous contents.
- R8: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. Without an issue, `out_valid`, `out_wr` and `out_illegal` are low and the results hold.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| in_a | input | XLEN | First operand, signed |
| in_b | input | XLEN | Second operand, signed |
| in_c | input | XLEN | Coefficient, signed |
| in_shift | input | SHW | Rounding shift amount `n` |
| in_rt | input | 5 | Destination index for the sum result |
| in_rc | input | 1 | Reserved record bit; 1 makes the issue illegal |
| out_valid | output | 1 | An issue completed this cycle |
| out_illegal | output | 1 | The completed issue was illegal |
| out_wr | output | 1 | The results and indices are to be written |
| out_rt_val | output | XLEN | Rounded sum-product |
| out_rs_val | output | XLEN | Rounded difference-product |
| out_rt_idx | output | 5 | Destination index for `out_rt_val` |
| out_rs_idx | output | 5 | Destination index for `out_rs_val` (rt+1) |

## Verification
The assertions check the timing and the flags on every cycle: the one-cycle valid latency, illegal issues suppressing the write, results holding when nothing is written, the pairing of the index with rt+1, and the exact truncated product when the shift is zero. The rounding arithmetic for nonzero shifts can only be shown by the bench's scenarios. These include tie cases, sign fill for negative products, the most negative 16-bit values, the largest 5-bit shift, and products that wrap past XLEN bits, each compared against an independent model.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    localparam int SHIFT_W = 5;
    localparam int IDX_W   = 5;

    typedef logic [IDX_W-1:0] reg_idx_t;

    // Implicit partner register: the next index, wrapping at the top.
    function automatic reg_idx_t partner_idx(input reg_idx_t rt);
        return rt + reg_idx_t'(1);
    endfunction

endpackage

// File: rtl/tbf_round_shift.sv
// Round-to-nearest by 2^n: add a bit at n-1, rotate right by n,
// keep the low XLEN-n bits and fill the rest with the sign.
module tbf_round_shift #(
    parameter int XLEN = 64,
    parameter int SHW  = 5
) (
    input  logic [XLEN-1:0] prod,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);
    localparam logic [XLEN-1:0] ONE  = XLEN'(1);
    localparam logic [XLEN-1:0] ONES = '1;

    logic [XLEN-1:0] bias;
    logic [XLEN-1:0] biased;
    logic [XLEN-1:0] rot;
    logic [XLEN-1:0] keep;
    logic            sgn;

    always_comb begin
        bias   = (shamt == '0) ? '0 : (ONE << (shamt - SHW'(1)));
        biased = prod + bias;
        rot    = (biased >> shamt) | (biased << (XLEN - int'(shamt)));
        keep   = ONES >> shamt;
        sgn    = biased[XLEN-1];
        res    = (rot & keep) | ({XLEN{sgn}} & ~keep);
    end

endmodule

// File: rtl/tbf_lane.sv
// One butterfly leg: (a +/- b) * c, truncated, then rounded.
module tbf_lane #(
    parameter int XLEN     = 64,
    parameter int SHW      = 5,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] combined;
    logic [XLEN-1:0] prod_lo;

    generate
        if (SUBTRACT) begin : g_diff
            assign combined = a - b;
        end else begin : g_sum
            assign combined = a + b;
        end
    endgenerate

    // Low half of a two's-complement product is sign-agnostic.
    assign prod_lo = combined * c;

    tbf_round_shift #(
        .XLEN (XLEN),
        .SHW  (SHW)
    ) u_rnd (
        .prod  (prod_lo),
        .shamt (shamt),
        .res   (res)
    );

endmodule

// File: rtl/tbf_twin_round.sv
module tbf_twin_round #(
    parameter int XLEN = 64,
    parameter int SHW  = tbf_pkg::SHIFT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [XLEN-1:0]          in_a,
    input  logic [XLEN-1:0]          in_b,
    input  logic [XLEN-1:0]          in_c,
    input  logic [SHW-1:0]           in_shift,
    input  logic [tbf_pkg::IDX_W-1:0] in_rt,
    input  logic                     in_rc,
    output logic                     out_valid,
    output logic                     out_illegal,
    output logic                     out_wr,
    output logic [XLEN-1:0]          out_rt_val,
    output logic [XLEN-1:0]          out_rs_val,
    output logic [tbf_pkg::IDX_W-1:0] out_rt_idx,
    output logic [tbf_pkg::IDX_W-1:0] out_rs_idx
);
    import tbf_pkg::*;

    localparam int NLANES = 2;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic            wr;
        logic [XLEN-1:0] rt_val;
        logic [XLEN-1:0] rs_val;
        reg_idx_t        rt_idx;
        reg_idx_t        rs_idx;
    } state_t;

    logic [XLEN-1:0] lane_res [NLANES];
    state_t          st_d;
    state_t          st_q;

    // Lane 0 forms the sum leg, lane 1 the difference leg.
    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            tbf_lane #(
                .XLEN     (XLEN),
                .SHW      (SHW),
                .SUBTRACT (g == 1)
            ) u_lane (
                .a     (in_a),
                .b     (in_b),
                .c     (in_c),
                .shamt (in_shift),
                .res   (lane_res[g])
            );
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.illegal = in_valid & in_rc;
        st_d.wr      = in_valid & ~in_rc;
        if (in_valid && !in_rc) begin
            st_d.rt_val = lane_res[0];
            st_d.rs_val = lane_res[1];
            st_d.rt_idx = in_rt;
            st_d.rs_idx = partner_idx(in_rt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_wr      = st_q.wr;
    assign out_rt_val  = st_q.rt_val;
    assign out_rs_val  = st_q.rs_val;
    assign out_rt_idx  = st_q.rt_idx;
    assign out_rs_idx  = st_q.rs_idx;

endmodule

// File: rtl/tbf_twin_round_chk.sv
module tbf_twin_round_chk #(
    parameter int XLEN = 64,
    parameter int SHW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic [XLEN-1:0] in_c,
    input logic [SHW-1:0]  in_shift,
    input logic [4:0]      in_rt,
    input logic            in_rc,
    input logic            out_valid,
    input logic            out_illegal,
    input logic            out_wr,
    input logic [XLEN-1:0] out_rt_val,
    input logic [XLEN-1:0] out_rs_val,
    input logic [4:0]      out_rt_idx,
    input logic [4:0]      out_rs_idx
);
    logic [XLEN-1:0] sum_prod;
    logic [XLEN-1:0] diff_prod;
    assign sum_prod  = (in_a + in_b) * in_c;
    assign diff_prod = (in_a - in_b) * in_c;

    assert_issue_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr && !out_illegal));

    assert_rc_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rc) |=> (out_illegal && !out_wr));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !in_rc) |=> ($stable(out_rt_val) && $stable(out_rs_val)
                                   && $stable(out_rt_idx)));

    assert_pair_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_rc) |=> (out_rt_idx == $past(in_rt)
                                  && out_rs_idx == 5'($past(in_rt) + 5'd1)));

    assert_zero_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_rc && in_shift == '0) |=>
            (out_rt_val == $past(sum_prod) && out_rs_val == $past(diff_prod)));

    assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_wr && out_illegal));

endmodule

bind tbf_twin_round tbf_twin_round_chk #(
    .XLEN (XLEN),
    .SHW  (SHW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .in_c        (in_c),
    .in_shift    (in_shift),
    .in_rt       (in_rt),
    .in_rc       (in_rc),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_wr      (out_wr),
    .out_rt_val  (out_rt_val),
    .out_rs_val  (out_rs_val),
    .out_rt_idx  (out_rt_idx),
    .out_rs_idx  (out_rs_idx)
);

// File: tb/tbf_twin_round_tb.sv
module tbf_twin_round_tb;

    localparam int XLEN = 64;
    localparam int NVEC = 12;

    typedef struct packed {
        logic signed [15:0] a;
        logic signed [15:0] b;
        logic signed [15:0] c;
        logic [4:0]         sh;
        logic [4:0]         rt;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{16'sd100,    16'sd50,     16'sd11585,  5'd14, 5'd3},
        '{-16'sd32768, 16'sd32767,  16'sd11585,  5'd14, 5'd7},
        '{16'sd32767,  16'sd32767,  16'sd32767,  5'd14, 5'd0},
        '{-16'sd32768, -16'sd32768, -16'sd32768, 5'd14, 5'd9},
        '{16'sd1234,   -16'sd4321,  -16'sd15137, 5'd14, 5'd12},
        '{-16'sd7,     16'sd3,      16'sd5,      5'd0,  5'd20},
        '{16'sd9,      -16'sd9,     -16'sd1,     5'd1,  5'd2},
        '{-16'sd1,     16'sd0,      16'sd1,      5'd1,  5'd5},
        '{16'sd255,    -16'sd256,   16'sd6270,   5'd5,  5'd30},
        '{-16'sd20000, 16'sd19999,  -16'sd6270,  5'd31, 5'd1},
        '{16'sd5,      16'sd5,      -16'sd32768, 5'd16, 5'd8},
        '{16'sd0,      16'sd0,      16'sd0,      5'd3,  5'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] in_a = '0;
    logic [XLEN-1:0] in_b = '0;
    logic [XLEN-1:0] in_c = '0;
    logic [4:0]      in_shift = '0;
    logic [4:0]      in_rt = '0;
    logic            in_rc = 1'b0;
    logic            out_valid, out_illegal, out_wr;
    logic [XLEN-1:0] out_rt_val, out_rs_val;
    logic [4:0]      out_rt_idx, out_rs_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tbf_twin_round #(.XLEN(XLEN)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_c        (in_c),
        .in_shift    (in_shift),
        .in_rt       (in_rt),
        .in_rc       (in_rc),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_wr      (out_wr),
        .out_rt_val  (out_rt_val),
        .out_rs_val  (out_rs_val),
        .out_rt_idx  (out_rt_idx),
        .out_rs_idx  (out_rs_idx)
    );

    function automatic longint model(input longint p, input int n);
        if (n == 0) return p;
        return (p + (64'sd1 <<< (n - 1))) >>> n;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the result registers on the next rising edge
    // and is sampled at the falling edge after it.
    task automatic issue(input longint a, input longint b, input longint c,
                         input int sh, input int rt, input bit rc);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a; in_b = b; in_c = c;
        in_shift = 5'(sh); in_rt = 5'(rt); in_rc = rc;
        @(negedge clk);
        in_valid = 1'b0;
        in_rc = 1'b0;
    endtask

    task automatic run_legal(input longint a, input longint b, input longint c,
                             input int sh, input int rt);
        issue(a, b, c, sh, rt, 1'b0);
        check("R1 sum", out_rt_val, model((a + b) * c, sh));
        check("R2 diff", out_rs_val, model((a - b) * c, sh));
        check("R6 rt idx", longint'(out_rt_idx), longint'(rt));
        check("R6 rs idx", longint'(out_rs_idx), longint'((rt + 1) % 32));
        check("R8 valid", longint'({out_valid, out_wr, out_illegal}), 64'd6);
    endtask

    initial begin
        longint prev_rt, prev_rs;
        logic [31:0] lfsr = 32'hACE1_2468;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset flags", longint'({out_valid, out_illegal, out_wr}), 0);
        check("R9 reset vals", out_rt_val | out_rs_val, 0);
        check("R9 reset idx", longint'({out_rt_idx, out_rs_idx}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_legal(longint'(VEC[i].a), longint'(VEC[i].b), longint'(VEC[i].c),
                      int'(VEC[i].sh), int'(VEC[i].rt));
        end

        // Pseudo-random 16-bit operands and shifts (R1, R2)
        for (int i = 0; i < 40; i++) begin
            longint ra, rb, rcoef;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ra = longint'($signed(lfsr[15:0]));
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            rb = longint'($signed(lfsr[31:16]));
            rcoef = longint'($signed(lfsr[15:0]));
            run_legal(ra, rb, rcoef, int'(lfsr[20:16]), int'(lfsr[25:21]));
        end

        // R5: ties toward +inf and sign fill
        issue(3, 0, 1, 1, 10, 1'b0);
        check("R5 tie pos", out_rt_val, 2);
        issue(-3, 0, 1, 1, 10, 1'b0);
        check("R5 tie neg", out_rt_val, -1);
        issue(-1000, 0, 1000, 14, 10, 1'b0);
        check("R5 sign fill", out_rt_val, -61);

        // R4: no rounding bit at shift zero
        issue(-7, 2, 3, 0, 11, 1'b0);
        check("R4 sum", out_rt_val, -15);
        check("R4 diff", out_rs_val, -27);

        // R3: products wrap modulo 2^64
        issue(64'sh4000_0000_0000_0000, 64'sh4000_0000_0000_0000, 2, 0, 13, 1'b0);
        check("R3 sum wrap", out_rt_val, 0);
        check("R3 diff", out_rs_val, 0);
        issue(64'sh7FFF_FFFF_FFFF_FFFF, 1, 1, 0, 13, 1'b0);
        check("R3 add wrap", out_rt_val, 64'sh8000_0000_0000_0000);

        // R6: index 31 pairs with 0
        issue(1, 1, 1, 0, 31, 1'b0);
        check("R6 wrap rt", longint'(out_rt_idx), 31);
        check("R6 wrap rs", longint'(out_rs_idx), 0);

        // R7: reserved bit set -> illegal, nothing written
        prev_rt = out_rt_val;
        prev_rs = out_rs_val;
        issue(500, 77, 9, 2, 6, 1'b1);
        check("R7 illegal", longint'(out_illegal), 1);
        check("R7 no wr", longint'(out_wr), 0);
        check("R7 valid", longint'(out_valid), 1);
        check("R7 rt held", out_rt_val, prev_rt);
        check("R7 rs held", out_rs_val, prev_rs);
        check("R7 idx held", longint'(out_rt_idx), 31);

        // R8: idle cycle after an issue
        @(negedge clk);
        check("R8 idle flags", longint'({out_valid, out_wr, out_illegal}), 0);
        check("R8 idle hold", out_rt_val, prev_rt);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule